// File: doc/BRIEF.md
# ISA I/O Bridge with Indirect Address Latch

This block connects a 16-bit ISA I/O slot to the host port of a target board. A jumper value selects an eight-byte window in ISA I/O space. Within that window, ISA address bits 2:0 pick a port offset. Two offsets are active.

Offset 2 is the address port. A write there loads a 16-bit address register, and that register drives the target's address lines. A read there fires an interrupt request toward the target. Offset 0 is the data port. Reads and writes there pass straight through to the target's active-low read and write strobes, and the data bus is routed directly in the matching direction.

The bridge also signals a 16-bit-capable cycle to the ISA bus. It inserts wait states while the target reports that it is busy. It drives the target's active-low reset from the ISA reset. A bare ISA read strobe is too short for the target to notice, so the interrupt is stretched to a programmable minimum width. All register state lives in one clock domain, and the ISA inputs are taken as synchronous to that clock.

Top module: `isa_host_bridge`

## Requirements
- R1: The board is selected only when ISA address bits 9:3 equal `jumperSel` and `isaAen` is 0. With `jumperSel` = 7'b1100000 the window is I/O 0x300 to 0x307. `isaIocs16N` is 0 exactly while the board is selected, and 1 otherwise.
- R2: `isaIochrdyN` is 0 only while the board is selected and `tgtExwaitN` is 0. Otherwise it is 1.
- R3: A selected read at offset 0 drives `tgtIorN` to 0, sets `isaDataOe` to 1 and presents `tgtDataIn` on `isaDataOut`. A selected write at offset 0 drives `tgtIowN` to 0, sets `tgtDataOe` to 1 and presents `isaDataIn` on `tgtDataOut`. Any other access leaves both strobes at 1 and both enables at 0.
- R4: `tgtEx1N` is 0 exactly while a selected offset-0 read or write strobe is active.
- R5: A selected write at offset 2 loads `isaDataIn` into the address register at the next rising clock edge. The register drives `tgtAddr`. No other access changes it.
- R6: While `isaReset` is 1, the address register is 0x0000 and `tgtVintN` is 1.
- R7: `tgtResN` is always the inverse of `isaReset`.
- R8: A rising edge of the selected read strobe at offset 2 drives `tgtVintN` to 0 from the next clock edge for exactly `VINT_WIDTH` clock cycles, default 16. This holds however long the read strobe is held. A new rising edge while the pulse is running restarts the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| isaReset | input | 1 | ISA reset, active high |
| isaAddr | input | 10 | ISA I/O address bits 9:0 |
| isaAen | input | 1 | ISA address enable; 1 marks a DMA cycle |
| isaIorN | input | 1 | ISA I/O read strobe, active low |
| isaIowN | input | 1 | ISA I/O write strobe, active low |
| isaDataIn | input | 16 | Data driven by the ISA host |
| isaDataOut | output | 16 | Data returned to the ISA host |
| isaDataOe | output | 1 | Enable for driving the ISA data bus |
| jumperSel | input | 7 | Jumper setting compared with address bits 9:3 |
| isaIocs16N | output | 1 | 16-bit cycle request, active low |
| isaIochrdyN | output | 1 | Channel-ready pull-down; 0 inserts wait states |
| tgtAddr | output | 16 | Latched address to the target |
| tgtDataOut | output | 16 | Data driven toward the target |
| tgtDataOe | output | 1 | Enable for driving the target data bus |
| tgtDataIn | input | 16 | Data returned by the target |
| tgtIorN | output | 1 | Target read strobe, active low |
| tgtIowN | output | 1 | Target write strobe, active low |
| tgtEx1N | output | 1 | Target access-select, active low |
| tgtResN | output | 1 | Target reset, active low |
| tgtVintN | output | 1 | Target interrupt request, active low |
| tgtExwaitN | input | 1 | Target busy flag, active low |

## Verification
Assertions check on every clock cycle the following:
- The address register holds unless a write to offset 2 is decoded, and it then captures the write data.
- The interrupt goes low on the cycle after a read-strobe rising edge.
- The pulse counter never exceeds its programmed width.
- Wait requests occur only inside a 16-bit cycle.
- The target-select line tracks the offset-0 strobes.

Only the bench scenarios can show the following:
- The exact length of the interrupt pulse under a long-held read strobe and under a retrigger.
- The rejection of DMA cycles and neighbouring windows.
- The reset values seen at the ports.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

  typedef struct packed {
    logic sel;     // board window matched
    logic rdData;  // read strobe at the data port
    logic wrData;  // write strobe at the data port
    logic rdAddr;  // read strobe at the address port
    logic wrAddr;  // write strobe at the address port
  } bridge_strobe_t;

endpackage

// File: rtl/isa_bridge_ctrl.sv
module isa_bridge_ctrl
  import isa_bridge_pkg::*;
#(
  parameter int SEL_W       = 7,
  parameter int ISA_A_W     = 10,
  parameter int OFF_W       = 3,
  parameter int DATA_OFF    = 0,
  parameter int ADDR_OFF    = 2,
  parameter int VINT_WIDTH  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ISA_A_W-1:0] isaAddr,
  input  logic               isaAen,
  input  logic               isaIorN,
  input  logic               isaIowN,
  input  logic [SEL_W-1:0]   jumperSel,
  output bridge_strobe_t     stb,
  output logic               vintN
);

  localparam int CNT_W = (VINT_WIDTH < 1) ? 1 : $clog2(VINT_WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(VINT_WIDTH);

  logic [OFF_W-1:0] offset;
  logic             selHit;

  assign offset = isaAddr[OFF_W-1:0];
  assign selHit = ({isaAddr[ISA_A_W-1:OFF_W], isaAen} == {jumperSel, 1'b0});

  always_comb begin
    stb.sel    = selHit;
    stb.rdData = selHit && !isaIorN && (offset == OFF_W'(DATA_OFF));
    stb.wrData = selHit && !isaIowN && (offset == OFF_W'(DATA_OFF));
    stb.rdAddr = selHit && !isaIorN && (offset == OFF_W'(ADDR_OFF));
    stb.wrAddr = selHit && !isaIowN && (offset == OFF_W'(ADDR_OFF));
  end

  logic rdAddrQ;
  logic rdAddrRise;

  always_ff @(posedge clk) begin
    if (rst) rdAddrQ <= 1'b0;
    else     rdAddrQ <= stb.rdAddr;
  end

  assign rdAddrRise = stb.rdAddr && !rdAddrQ;

  generate
    if (VINT_WIDTH > 0) begin : g_stretch
      logic [CNT_W-1:0] pulseCnt;

      always_ff @(posedge clk) begin
        if (rst)             pulseCnt <= '0;
        else if (rdAddrRise) pulseCnt <= CNT_LOAD;
        else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
      end

      assign vintN = (pulseCnt == '0);

      a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        pulseCnt <= CNT_LOAD);
    end else begin : g_raw
      assign vintN = !stb.rdAddr;
    end
  endgenerate

  a_r8_pulse_start: assert property (@(posedge clk) disable iff (rst)
    rdAddrRise |=> !vintN);

  a_r3_one_offset: assert property (@(posedge clk) disable iff (rst)
    $countones({stb.rdData, stb.rdAddr}) <= 1);

endmodule

// File: rtl/isa_bridge_dp.sv
module isa_bridge_dp
  import isa_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  bridge_strobe_t     stb,
  input  logic [DATA_W-1:0]  isaDataIn,
  output logic [DATA_W-1:0]  isaDataOut,
  output logic               isaDataOe,
  input  logic [DATA_W-1:0]  tgtDataIn,
  output logic [DATA_W-1:0]  tgtDataOut,
  output logic               tgtDataOe,
  output logic [TADDR_W-1:0] tgtAddr
);

  logic [TADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (rst)             addrQ <= '0;
    else if (stb.wrAddr) addrQ <= TADDR_W'(isaDataIn);
  end

  assign tgtAddr    = addrQ;
  assign isaDataOe  = stb.rdData;
  assign isaDataOut = stb.rdData ? tgtDataIn : '0;
  assign tgtDataOe  = stb.wrData;
  assign tgtDataOut = stb.wrData ? isaDataIn : '0;

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.wrAddr |=> $stable(addrQ));

  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    stb.wrAddr |=> (addrQ == TADDR_W'($past(isaDataIn))));

endmodule

// File: rtl/isa_host_bridge.sv
module isa_host_bridge
  import isa_bridge_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int TADDR_W    = 16,
  parameter int VINT_WIDTH = 16
) (
  input  logic               clk,
  input  logic               isaReset,
  input  logic [9:0]         isaAddr,
  input  logic               isaAen,
  input  logic               isaIorN,
  input  logic               isaIowN,
  input  logic [DATA_W-1:0]  isaDataIn,
  output logic [DATA_W-1:0]  isaDataOut,
  output logic               isaDataOe,
  input  logic [6:0]         jumperSel,
  output logic               isaIocs16N,
  output logic               isaIochrdyN,
  output logic [TADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0]  tgtDataOut,
  output logic               tgtDataOe,
  input  logic [DATA_W-1:0]  tgtDataIn,
  output logic               tgtIorN,
  output logic               tgtIowN,
  output logic               tgtEx1N,
  output logic               tgtResN,
  output logic               tgtVintN,
  input  logic               tgtExwaitN
);

  bridge_strobe_t stb;

  isa_bridge_ctrl #(
    .SEL_W(7), .ISA_A_W(10), .OFF_W(3),
    .DATA_OFF(0), .ADDR_OFF(2), .VINT_WIDTH(VINT_WIDTH)
  ) u_ctrl (
    .clk(clk), .rst(isaReset), .isaAddr(isaAddr), .isaAen(isaAen),
    .isaIorN(isaIorN), .isaIowN(isaIowN), .jumperSel(jumperSel),
    .stb(stb), .vintN(tgtVintN)
  );

  isa_bridge_dp #(.DATA_W(DATA_W), .TADDR_W(TADDR_W)) u_dp (
    .clk(clk), .rst(isaReset), .stb(stb),
    .isaDataIn(isaDataIn), .isaDataOut(isaDataOut), .isaDataOe(isaDataOe),
    .tgtDataIn(tgtDataIn), .tgtDataOut(tgtDataOut), .tgtDataOe(tgtDataOe),
    .tgtAddr(tgtAddr)
  );

  assign isaIocs16N  = !stb.sel;
  assign isaIochrdyN = !(stb.sel && !tgtExwaitN);
  assign tgtIorN     = !stb.rdData;
  assign tgtIowN     = !stb.wrData;
  assign tgtEx1N     = !(stb.rdData || stb.wrData);
  assign tgtResN     = !isaReset;

  a_r2_wait_in_cycle: assert property (@(posedge clk) disable iff (isaReset)
    !isaIochrdyN |-> !isaIocs16N);

  a_r4_ex1_tracks: assert property (@(posedge clk) disable iff (isaReset)
    (!tgtEx1N) == (!tgtIorN || !tgtIowN));

endmodule

// File: tb/tb_isa_host_bridge.sv
module tb_isa_host_bridge;

  localparam int W = 16;
  localparam logic [6:0] JMP = 7'b1100000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        isaReset, isaAen, isaIorN, isaIowN, tgtExwaitN;
  logic [9:0]  isaAddr;
  logic [15:0] isaDataIn, tgtDataIn;
  logic [6:0]  jumperSel;
  logic [15:0] isaDataOut, tgtAddr, tgtDataOut;
  logic isaDataOe, isaIocs16N, isaIochrdyN, tgtDataOe;
  logic tgtIorN, tgtIowN, tgtEx1N, tgtResN, tgtVintN;

  isa_host_bridge dut (.*);

  int nRun = 0, nFail = 0;
  logic [15:0] mAddr;
  int mCnt;
  logic mPrev;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic selOf(logic [9:0] a, logic aen, logic [6:0] j);
    return (a[9:3] == j) && !aen;
  endfunction

  // one cycle: check registered outputs, apply inputs, check combinational, advance model
  task automatic step(logic rst, logic [9:0] a, logic aen, logic rdN, logic wrN,
                      logic [15:0] dIn, logic [15:0] tIn, logic exw);
    logic s, rd0, wr0, rd2, wr2;
    @(negedge clk);
    chk("R5/R6 tgtAddr", tgtAddr, mAddr);
    chk("R8/R6 tgtVintN", tgtVintN, (mCnt == 0));
    isaReset = rst; isaAddr = a; isaAen = aen; isaIorN = rdN; isaIowN = wrN;
    isaDataIn = dIn; tgtDataIn = tIn; tgtExwaitN = exw;
    #1;
    s   = selOf(a, aen, jumperSel);
    rd0 = s && !rdN && a[2:0] == 3'd0;
    wr0 = s && !wrN && a[2:0] == 3'd0;
    rd2 = s && !rdN && a[2:0] == 3'd2;
    wr2 = s && !wrN && a[2:0] == 3'd2;
    chk("R1 isaIocs16N", isaIocs16N, !s);
    chk("R2 isaIochrdyN", isaIochrdyN, !(s && !exw));
    chk("R3 tgtIorN", tgtIorN, !rd0);
    chk("R3 tgtIowN", tgtIowN, !wr0);
    chk("R3 isaDataOe", isaDataOe, rd0);
    chk("R3 tgtDataOe", tgtDataOe, wr0);
    if (rd0) chk("R3 isaDataOut", isaDataOut, tIn);
    if (wr0) chk("R3 tgtDataOut", tgtDataOut, dIn);
    chk("R4 tgtEx1N", tgtEx1N, !(rd0 || wr0));
    chk("R7 tgtResN", tgtResN, !rst);
    if (rst) begin
      mAddr = 16'h0; mCnt = 0; mPrev = 1'b0;
    end else begin
      if (wr2) mAddr = dIn;
      if (rd2 && !mPrev) mCnt = 16;
      else if (mCnt > 0) mCnt--;
      mPrev = rd2;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 10'h000, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0, 1'b1);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int lowCnt;
    void'($urandom(32'hC0FFEE));
    jumperSel = JMP;
    isaReset = 1'b1; isaAddr = '0; isaAen = 1'b0; isaIorN = 1'b1; isaIowN = 1'b1;
    isaDataIn = '0; tgtDataIn = '0; tgtExwaitN = 1'b1;
    mAddr = '0; mCnt = 0; mPrev = 1'b0;
    // R6 reset state
    repeat (3) step(1'b1, 10'h302, 1'b0, 1'b1, 1'b0, 16'hBEEF, 16'h0, 1'b1);
    step(1'b0, 10'h000, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0, 1'b1);
    // R1 window edges, DMA cycle rejected
    step(1'b0, 10'h300, 1'b0, 1'b0, 1'b1, 16'h0, 16'h1234, 1'b0);
    step(1'b0, 10'h307, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0, 1'b0);
    step(1'b0, 10'h308, 1'b0, 1'b0, 1'b1, 16'h0, 16'h5555, 1'b0);
    step(1'b0, 10'h2F8, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 1'b0);
    step(1'b0, 10'h300, 1'b1, 1'b0, 1'b0, 16'h7777, 16'h0, 1'b0);
    // R5 address load, then DMA-cycle and neighbour writes ignored
    step(1'b0, 10'h302, 1'b0, 1'b1, 1'b0, 16'h0123, 16'h0, 1'b1);
    step(1'b0, 10'h302, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0, 1'b1);
    step(1'b0, 10'h30A, 1'b0, 1'b1, 1'b0, 16'hAAAA, 16'h0, 1'b1);
    step(1'b0, 10'h303, 1'b0, 1'b1, 1'b0, 16'h5A5A, 16'h0, 1'b1);
    step(1'b0, 10'h300, 1'b0, 1'b1, 1'b0, 16'hCAFE, 16'h0, 1'b1);
    idle(1);
    chk("R5 addr held", tgtAddr, 16'h0123);
    // R8 long-held read of offset 2: width must stay exactly 16
    lowCnt = 0;
    for (int i = 0; i < 30; i++) begin
      step(1'b0, 10'h302, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b1);
      if (tgtVintN === 1'b0) lowCnt++;
    end
    chk("R8 held strobe pulse width", lowCnt, 16);
    idle(3);
    // R8 retrigger restarts the width
    step(1'b0, 10'h302, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b1);
    idle(5);
    step(1'b0, 10'h302, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b1);
    lowCnt = 0;
    for (int i = 0; i < 25; i++) begin
      idle(1);
      if (tgtVintN === 1'b0) lowCnt++;
    end
    chk("R8 retrigger width", lowCnt, 16);
    // R6 reset during pulse
    step(1'b0, 10'h302, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b1);
    idle(2);
    step(1'b1, 10'h000, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0, 1'b1);
    idle(2);
    // alternate jumper setting
    jumperSel = 7'b0101010;
    step(1'b0, 10'h150, 1'b0, 1'b0, 1'b1, 16'h0, 16'h9999, 1'b0);
    step(1'b0, 10'h152, 1'b0, 1'b1, 1'b0, 16'h4321, 16'h0, 1'b1);
    step(1'b0, 10'h300, 1'b0, 1'b0, 1'b1, 16'h0, 16'h1111, 1'b0);
    jumperSel = JMP;
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] a;
      logic rdN, wrN;
      int k = $urandom_range(0, 9);
      a = (k < 7) ? {JMP, 3'($urandom_range(0, 7))} : 10'($urandom);
      rdN = ($urandom_range(0, 2) != 0);
      wrN = rdN ? ($urandom_range(0, 1) == 0) : 1'b1;
      step(($urandom_range(0, 199) == 0), a, ($urandom_range(0, 7) == 0),
           rdN, wrN, 16'($urandom), 16'($urandom), 1'($urandom));
    end
    idle(2);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule